// File: doc/BRIEF.md
# Calendar Clock with Minute Countdown and Alarm

This block keeps wall-clock time for a chip: seconds, minutes and hours packed into one 32-bit word, plus a 9-bit count of days. It advances once for each pulse on a one-second tick input. The pulse comes from logic outside the block. A countdown counter in whole minutes and a time-of-day-plus-day alarm run alongside the clock.

Each kind of event sets its own bit in a sticky status register. An event bit latches only if its bit in the enable register is set. One interrupt line reports any pending event that is enabled. Software reaches all eight registers through a simple synchronous write port and a combinational read port, both indexed by a 3-bit address.

Top module: `rtc_clock`

## Requirements
- R1: Register addresses: 0 time, 1 day, 2 alarm time, 3 alarm day, 4 stopwatch, 5 control, 6 event enable, 7 event status. The time word holds seconds in bits 5:0, minutes in bits 21:16 and hours in bits 28:24, and all other bits read 0. Every register reads back what was last written to it, masked to its width.
- R2: While control bit 7 is 0, `sec_tick` pulses change neither the time, the day count, the stopwatch nor the status register.
- R3: An accepted tick always raises event bit 4 and advances the seconds. When the seconds are at 59 they go to 0, the minutes advance and event bit 1 is raised. When the minutes are at 59 they go to 0, the hours advance and event bit 5 is raised. When the hours are at 23 they go to 0, the day count advances and event bit 3 is raised.
- R4: The day count is 9 bits wide and wraps from 511 to 0.
- R5: On each minute rollover the stopwatch behaves as follows. A value of 63 holds. A value of 0 becomes 63. Any other value decrements by 1.
- R6: On a minute rollover, event bit 0 is raised when the stopwatch holds 63 or 0 beforehand, that is, when it reads 63 after the update.
- R7: Event bit 6 is raised when, after a tick, the updated time word equals the alarm word and the day count equals the alarm day.
- R8: A raised event is ANDed with its bit in the enable register before it is ORed into the status register. The `irq` output is high exactly when some status bit and its enable bit are both 1.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event sets the same bit in the same cycle, the set wins.
- R10: A write to the time or day register takes effect at the next clock edge and raises no event. A tick in the same cycle as such a write is dropped.
- R11: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench drives the full chain of carries: seconds only, seconds into minutes, minutes into hours, hours into days, and the day count wrapping from 511 to 0. A carry that skipped a stage would show up as a wrong time word or a missing event bit.

It drives the stopwatch through the sentinel 63, through 0 and through an ordinary value. A design that decremented 63, or let 0 wrap to 62, would fail these cases.

The alarm is checked once with a matching day and once with a mismatching day. A compare that ignored the day, or used the old time instead of the updated time, would raise bit 6 at the wrong moment.

The bench also covers enable masking, write-1-to-clear, and ticks that arrive while the clock is stopped or in the same cycle as a time write. These catch designs that latch masked events, clear on write-0, or count a tick that should have been dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DAY_W  = 9;
    localparam int SW_W   = 6;
    localparam int EVT_W  = 7;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // event bit positions (software decodes these)
    localparam int EV_SW    = 0;
    localparam int EV_MIN   = 1;
    localparam int EV_DAY   = 3;
    localparam int EV_SEC   = 4;
    localparam int EV_HOUR  = 5;
    localparam int EV_ALARM = 6;

    localparam int CTL_RUN_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_TIME   = 3'd0,
        REG_DAY    = 3'd1,
        REG_ALTIME = 3'd2,
        REG_ALDAY  = 3'd3,
        REG_SWATCH = 3'd4,
        REG_CTRL   = 3'd5,
        REG_ENABLE = 3'd6,
        REG_STATUS = 3'd7
    } rtc_reg_e;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    function automatic rtc_time_t word_to_time(input logic [DATA_W-1:0] w);
        rtc_time_t t;
        t.hour = w[28:24];
        t.min  = w[21:16];
        t.sec  = w[5:0];
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] time_to_word(input rtc_time_t t);
        return {3'b000, t.hour, 2'b00, t.min, 10'd0, t.sec};
    endfunction
endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             wr_time,
    input  logic             wr_day,
    input  logic [DATA_W-1:0] wdata,
    input  rtc_time_t        alarm_time,
    input  logic [DAY_W-1:0] alarm_day,
    output rtc_time_t        now,
    output logic [DAY_W-1:0] day,
    output logic             min_roll,
    output logic [EVT_W-1:0] tk_evt
);
    rtc_time_t        nxt;
    logic [DAY_W-1:0] nxt_day;

    always_comb begin
        nxt     = now;
        nxt_day = day;
        tk_evt  = '0;
        if (advance) begin
            tk_evt[EV_SEC] = 1'b1;
            if (now.sec >= 6'd59) begin
                nxt.sec        = '0;
                tk_evt[EV_MIN] = 1'b1;
                if (now.min >= 6'd59) begin
                    nxt.min         = '0;
                    tk_evt[EV_HOUR] = 1'b1;
                    if (now.hour >= 5'd23) begin
                        nxt.hour       = '0;
                        nxt_day        = day + 1'b1;
                        tk_evt[EV_DAY] = 1'b1;
                    end else begin
                        nxt.hour = now.hour + 1'b1;
                    end
                end else begin
                    nxt.min = now.min + 1'b1;
                end
            end else begin
                nxt.sec = now.sec + 1'b1;
            end
            if (nxt == alarm_time && nxt_day == alarm_day)
                tk_evt[EV_ALARM] = 1'b1;
        end
    end

    assign min_roll = tk_evt[EV_MIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
            day <= '0;
        end else begin
            if (wr_time)      now <= word_to_time(wdata);
            else if (advance) now <= nxt;
            if (wr_day)       day <= wdata[DAY_W-1:0];
            else if (advance) day <= nxt_day;
        end
    end

    assert_sec_step_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && now.sec < 6'd59) |=> (now.sec == $past(now.sec) + 6'd1));

    assert_day_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && day == '1 && now.hour == 5'd23 && now.min == 6'd59 && now.sec == 6'd59)
        |=> (day == '0));
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            min_roll,
    input  logic            wr,
    input  logic [SW_W-1:0] wdata,
    output logic [SW_W-1:0] count,
    output logic            sw_evt
);
    localparam logic [SW_W-1:0] IDLE = '1;

    assign sw_evt = min_roll && (count == IDLE || count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (wr)
            count <= wdata;
        else if (min_roll && count != IDLE)
            count <= (count == '0) ? IDLE : count - 1'b1;
    end

    assert_zero_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (min_roll && !wr && count == '0) |=> (count == IDLE));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (min_roll && !wr && count == IDLE) |=> (count == IDLE));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] events,
    input  logic [EVT_W-1:0] enable,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_mask,
    output logic [EVT_W-1:0] status,
    output logic             irq
);
    logic [EVT_W-1:0] keep;

    assign keep = clr_wr ? ~clr_mask : '1;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & keep) | (events & enable);
    end

    assign irq = |(status & enable);

    assert_only_enabled_set_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((status & ~$past(status)) & ~$past(enable)) == '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/rtc_clock.sv
module rtc_clock
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    rtc_reg_e         sel;
    logic             wr_time, wr_day, wr_sw, wr_stat, run, advance;
    logic [7:0]       ctrl_q;
    rtc_time_t        alarm_q;
    logic [DAY_W-1:0] alarm_day_q;
    logic [EVT_W-1:0] enable_q;
    rtc_time_t        now;
    logic [DAY_W-1:0] day;
    logic [SW_W-1:0]  sw_count;
    logic             min_roll, sw_evt;
    logic [EVT_W-1:0] tk_evt, all_evt, status;

    assign sel     = rtc_reg_e'(addr);
    assign wr_time = wr_en && sel == REG_TIME;
    assign wr_day  = wr_en && sel == REG_DAY;
    assign wr_sw   = wr_en && sel == REG_SWATCH;
    assign wr_stat = wr_en && sel == REG_STATUS;
    assign run     = ctrl_q[CTL_RUN_BIT];
    assign advance = sec_tick && run && !wr_time && !wr_day;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            alarm_q     <= '0;
            alarm_day_q <= '0;
            enable_q    <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_ALTIME: alarm_q     <= word_to_time(wdata);
                REG_ALDAY:  alarm_day_q <= wdata[DAY_W-1:0];
                REG_CTRL:   ctrl_q      <= wdata[7:0];
                REG_ENABLE: enable_q    <= wdata[EVT_W-1:0];
                default: ;
            endcase
        end
    end

    rtc_timekeeper u_time (
        .clk(clk), .rst(rst), .advance(advance), .wr_time(wr_time), .wr_day(wr_day),
        .wdata(wdata), .alarm_time(alarm_q), .alarm_day(alarm_day_q),
        .now(now), .day(day), .min_roll(min_roll), .tk_evt(tk_evt)
    );

    rtc_stopwatch u_sw (
        .clk(clk), .rst(rst), .min_roll(min_roll), .wr(wr_sw),
        .wdata(wdata[SW_W-1:0]), .count(sw_count), .sw_evt(sw_evt)
    );

    always_comb begin
        all_evt        = tk_evt;
        all_evt[EV_SW] = sw_evt;
    end

    rtc_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .events(all_evt), .enable(enable_q),
        .clr_wr(wr_stat), .clr_mask(wdata[EVT_W-1:0]), .status(status), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            REG_TIME:   rdata = time_to_word(now);
            REG_DAY:    rdata[DAY_W-1:0] = day;
            REG_ALTIME: rdata = time_to_word(alarm_q);
            REG_ALDAY:  rdata[DAY_W-1:0] = alarm_day_q;
            REG_SWATCH: rdata[SW_W-1:0]  = sw_count;
            REG_CTRL:   rdata[7:0]       = ctrl_q;
            REG_ENABLE: rdata[EVT_W-1:0] = enable_q;
            REG_STATUS: rdata[EVT_W-1:0] = status;
            default:    rdata = '0;
        endcase
    end

    assert_halt_holds_time_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_time && !wr_day) |=> ($stable(now) && $stable(day)));

    assert_write_no_event_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_time || wr_day) |-> (tk_evt == '0));
endmodule

// File: tb/tb_rtc_clock.sv
module tb_rtc_clock;
    logic        clk = 1'b0;
    logic        rst;
    logic        sec_tick;
    logic        wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_clock dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] t0;
        logic [8:0]  d0;
        logic [5:0]  s0;
        logic [31:0] t1;
        logic [8:0]  d1;
        logic [5:0]  s1;
        logic [6:0]  st;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h0000_0005, 9'd3,   6'd63, 32'h0000_0006, 9'd3,   6'd63, 7'h10},
        '{32'h0005_003B, 9'd3,   6'd10, 32'h0006_0000, 9'd3,   6'd9,  7'h12},
        '{32'h033B_003B, 9'd3,   6'd0,  32'h0400_0000, 9'd3,   6'd63, 7'h33},
        '{32'h173B_003B, 9'd7,   6'd63, 32'h0000_0000, 9'd8,   6'd63, 7'h3B},
        '{32'h173B_003B, 9'd511, 6'd5,  32'h0000_0000, 9'd0,   6'd4,  7'h3A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; sec_tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R11 reset reg", v, 32'h0);
        end
        check("R11 reset irq", {31'b0, irq}, 32'h0);

        // R2 stopped clock ignores ticks
        wr(3'd0, 32'h0000_0010);
        tick();
        rd(3'd0, v); check("R2 time held", v, 32'h0000_0010);
        rd(3'd7, v); check("R2 no status", v, 32'h0);

        // R1 readback masking
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R1 alarm mask", v, 32'h1F3F_003F);
        wr(3'd2, 32'h0A00_0000);
        wr(3'd3, 32'd400);
        rd(3'd3, v); check("R1 alarm day", v, 32'd400);

        wr(3'd5, 32'h80);
        wr(3'd6, 32'h7F);
        rd(3'd6, v); check("R1 enable", v, 32'h7F);

        // vector table: R3 R4 R5 R6
        foreach (VEC[i]) begin
            wr(3'd0, VEC[i].t0);
            wr(3'd1, {23'b0, VEC[i].d0});
            wr(3'd4, {26'b0, VEC[i].s0});
            wr(3'd7, 32'h7F);
            tick();
            rd(3'd0, v); check("R3 time", v, VEC[i].t1);
            rd(3'd1, v); check("R4 day",  v, {23'b0, VEC[i].d1});
            rd(3'd4, v); check("R5 stopwatch", v, {26'b0, VEC[i].s1});
            rd(3'd7, v); check("R6 status", v, {25'b0, VEC[i].st});
        end

        // R7 alarm match and day mismatch
        wr(3'd2, 32'h0102_0004);
        wr(3'd3, 32'd9);
        wr(3'd4, 32'd20);
        wr(3'd0, 32'h0102_0003);
        wr(3'd1, 32'd9);
        wr(3'd7, 32'h7F);
        tick();
        rd(3'd7, v); check("R7 alarm hit", v, 32'h50);
        wr(3'd0, 32'h0102_0003);
        wr(3'd1, 32'd10);
        wr(3'd7, 32'h7F);
        tick();
        rd(3'd7, v); check("R7 day mismatch", v, 32'h10);

        // R8 enable gating
        wr(3'd7, 32'h7F);
        wr(3'd6, 32'h10);
        wr(3'd0, 32'h0000_003B);
        tick();
        rd(3'd7, v); check("R8 masked events", v, 32'h10);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        wr(3'd6, 32'h00);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(3'd7, v); check("R8 status kept", v, 32'h10);

        // R9 write-1-to-clear
        wr(3'd7, 32'h00);
        rd(3'd7, v); check("R9 write0 keeps", v, 32'h10);
        wr(3'd7, 32'h10);
        rd(3'd7, v); check("R9 write1 clears", v, 32'h0);

        // R10 write with no event, tick dropped in a write cycle
        wr(3'd6, 32'h7F);
        wr(3'd0, 32'h0203_0405);
        rd(3'd7, v); check("R10 no event", v, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h0000_0020; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(3'd0, v); check("R10 write wins", v, 32'h0000_0020);
        rd(3'd7, v); check("R10 tick dropped", v, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule